// File: doc/BRIEF.md
# Register-File Execution Datapath

This block is the execution half of a small single-issue processor. A control unit gives it, every cycle, a control word and a constant. The block reads two registers from an eight-entry register file. It can swap the second operand for the constant, and it runs one of nine arithmetic or logic functions. It then writes back either the function result or a word read from a small local data memory. The same edge can also store a register value into that memory. Four status flags (overflow, carry, negative, zero) go back to the control unit so that it can make branch decisions.

Both register reads and the memory read are combinational, so a whole instruction finishes in one clock. This includes loads and read-modify-write sequences. The A bus is the memory address. The second operand, after the constant multiplexer, is the store data. The status flags always describe the function unit's output, even when the memory word is the value being written back.

Top module: `regfile_datapath`

## Requirements
- R1: An active-low reset sets every register and every data memory word to zero.
- R2: When `wr_en` is 1, `wb_data` is written into the register selected by `dst_sel` on the rising clock edge. When `wr_en` is 0, no register changes.
- R3: `a_bus` shows the register chosen by `a_sel`. `b_bus` shows the register chosen by `b_sel` when `const_sel` is 0, and `const_in` when `const_sel` is 1.
- R4: `fsel` selects the function unit output F from A = `a_bus` and B = `b_bus`, modulo 2^DW. The codes are: 0 F = A; 1 F = A+1; 2 F = A+B; 3 F = A-B; 4 F = A-1; 5 F = A AND B; 6 F = A OR B; 7 F = A XOR B; 8 F = NOT A.
- R5: Add sets C to the carry out of the top bit. Subtract is formed as A + ~B + 1, so C = 1 means no borrow (A >= B unsigned). For both, V = 1 exactly when the signed result overflows.
- R6: Increment sets C only when A is all ones, and sets V only when A is the largest positive value. Decrement is A plus all ones: C = 0 only when A is zero, and V = 1 only when A is the most negative value.
- R7: Move, AND, OR, XOR and NOT force V = 0 and C = 0.
- R8: N equals the top bit of F, and Z is 1 exactly when F is zero. Both follow F whatever `res_sel` selects.
- R9: When `mem_we` is 1, `b_bus` is stored on the rising edge into the memory word addressed by the low MAW bits of `a_bus`. Higher address bits are ignored, so addresses wrap modulo the depth.
- R10: `wb_data` equals F when `res_sel` is 0. When `res_sel` is 1 it equals the memory word at the current address in the same cycle, and that word is the value stored before any write on the coming edge.
- R11: Function codes 9 to 15 behave exactly like code 0 (move).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| dst_sel | input | RAW | Destination register index |
| a_sel | input | RAW | A-side source register index |
| b_sel | input | RAW | B-side source register index |
| const_sel | input | 1 | 1 selects the constant as B operand |
| const_in | input | DW | Constant operand |
| fsel | input | 4 | Function select |
| mem_we | input | 1 | Data memory write enable |
| res_sel | input | 1 | Write-back select: 0 function result, 1 memory word |
| a_bus | output | DW | A operand, also the memory address |
| b_bus | output | DW | B operand, also the memory store data |
| wb_data | output | DW | Write-back value |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry / no borrow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
Every output follows the current inputs and the stored state combinationally, in the same cycle. Register and memory writes become visible one edge after the cycle that asks for them. The bench drives each control word just after a falling edge. A quarter period later it compares all outputs with a behavioural model, and it updates the model's registers and memory only after the next rising edge. A write is therefore checked in the following cycle. A load that reads a word being written in the same cycle must return the old word.

// File: rtl/regfile_datapath.sv
module regfile_datapath #(
  parameter int DW  = 8,
  parameter int RAW = 3,
  parameter int MAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] dst_sel,
  input  logic [RAW-1:0] a_sel,
  input  logic [RAW-1:0] b_sel,
  input  logic           const_sel,
  input  logic [DW-1:0]  const_in,
  input  logic [3:0]     fsel,
  input  logic           mem_we,
  input  logic           res_sel,
  output logic [DW-1:0]  a_bus,
  output logic [DW-1:0]  b_bus,
  output logic [DW-1:0]  wb_data,
  output logic           flag_v,
  output logic           flag_c,
  output logic           flag_n,
  output logic           flag_z
);
  localparam int NREG  = 1 << RAW;
  localparam int DEPTH = 1 << MAW;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] opnd, fres, mem_rd;
  logic [DW:0]   sum;
  logic          cin, arith;
  logic [MAW-1:0] maddr;

  assign a_bus  = regs[a_sel];
  assign b_bus  = const_sel ? const_in : regs[b_sel];
  assign maddr  = a_bus[MAW-1:0];
  assign mem_rd = mem[maddr];

  always_comb begin
    arith = 1'b1;
    cin   = 1'b0;
    opnd  = '0;
    fres  = a_bus;
    case (fsel)
      4'd1: opnd = {{(DW-1){1'b0}}, 1'b1};
      4'd2: opnd = b_bus;
      4'd3: begin opnd = ~b_bus; cin = 1'b1; end
      4'd4: opnd = '1;
      4'd5: begin arith = 1'b0; fres = a_bus & b_bus; end
      4'd6: begin arith = 1'b0; fres = a_bus | b_bus; end
      4'd7: begin arith = 1'b0; fres = a_bus ^ b_bus; end
      4'd8: begin arith = 1'b0; fres = ~a_bus; end
      default: arith = 1'b0;
    endcase
    if (arith) fres = sum[DW-1:0];
  end

  assign sum = {1'b0, a_bus} + {1'b0, opnd} + {{DW{1'b0}}, cin};

  assign flag_c  = arith & sum[DW];
  assign flag_v  = arith & (a_bus[DW-1] == opnd[DW-1]) & (sum[DW-1] != a_bus[DW-1]);
  assign flag_n  = fres[DW-1];
  assign flag_z  = (fres == '0);
  assign wb_data = res_sel ? mem_rd : fres;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[dst_sel] <= wb_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (mem_we) begin
      mem[maddr] <= b_bus;
    end
  end
endmodule

// File: rtl/regfile_datapath_chk.sv
module regfile_datapath_chk #(
  parameter int DW  = 8,
  parameter int RAW = 3,
  parameter int MAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [RAW-1:0] dst_sel,
  input logic [RAW-1:0] a_sel,
  input logic [3:0]     fsel,
  input logic           mem_we,
  input logic           res_sel,
  input logic [DW-1:0]  a_bus,
  input logic [DW-1:0]  b_bus,
  input logic [DW-1:0]  wb_data,
  input logic           flag_v,
  input logic           flag_c,
  input logic           flag_n,
  input logic           flag_z
);
  p_reg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (a_sel != $past(dst_sel)) || (a_bus == $past(wb_data)));

  p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (a_sel != $past(a_sel)) || $stable(a_bus));

  p_mem_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !wr_en) |=> !(res_sel && (a_bus[MAW-1:0] == $past(a_bus[MAW-1:0])))
                           || (wb_data == $past(b_bus)));

  p_no_arith_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 4'd0 || fsel >= 4'd5) |-> (!flag_v && !flag_c));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_sel |-> (flag_z == (wb_data == '0)));

  p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_sel |-> (flag_n == wb_data[DW-1]));

  p_inc_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 4'd1) |-> (flag_c == (a_bus == '1)));
endmodule

bind regfile_datapath regfile_datapath_chk #(.DW(DW), .RAW(RAW), .MAW(MAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dst_sel(dst_sel), .a_sel(a_sel),
  .fsel(fsel), .mem_we(mem_we), .res_sel(res_sel), .a_bus(a_bus), .b_bus(b_bus),
  .wb_data(wb_data), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/regfile_datapath_bench.sv
module regfile_datapath_bench;
  localparam int PER = 10;
  localparam int DW = 8, RAW = 3, MAW = 4;
  localparam int MASK = (1 << DW) - 1;
  localparam int TOP  = 1 << (DW - 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, const_sel = 0, mem_we = 0, res_sel = 0;
  logic [RAW-1:0] dst_sel = 0, a_sel = 0, b_sel = 0;
  logic [DW-1:0] const_in = 0;
  logic [3:0] fsel = 0;
  logic [DW-1:0] a_bus, b_bus, wb_data;
  logic flag_v, flag_c, flag_n, flag_z;

  int total = 0, bad = 0;
  int mregs [8];
  int mmem  [16];
  bit in_reset_phase = 1;

  always #(PER/2) clk = ~clk;

  regfile_datapath #(.DW(DW), .RAW(RAW), .MAW(MAW)) u_regfile_datapath (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dst_sel(dst_sel), .a_sel(a_sel),
    .b_sel(b_sel), .const_sel(const_sel), .const_in(const_in), .fsel(fsel),
    .mem_we(mem_we), .res_sel(res_sel), .a_bus(a_bus), .b_bus(b_bus),
    .wb_data(wb_data), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic addf(int a, int op, int ci, output int r, output int c, output int v);
    int s;
    s = a + op + ci;
    r = s & MASK;
    c = (s > MASK) ? 1 : 0;
    v = (((a & TOP) == (op & TOP)) && ((r & TOP) != (a & TOP))) ? 1 : 0;
  endtask

  task automatic step(bit w, int d, int as, int bs, bit cs, int k, int f, bit mw, bit md);
    int a, b, r, c, v, wb, fl;
    string ft;
    wr_en = w; dst_sel = d[RAW-1:0]; a_sel = as[RAW-1:0]; b_sel = bs[RAW-1:0];
    const_sel = cs; const_in = k[DW-1:0]; fsel = f[3:0]; mem_we = mw; res_sel = md;
    #(PER/4);
    a = mregs[as]; b = cs ? (k & MASK) : mregs[bs];
    c = 0; v = 0;
    case (f)
      1: begin addf(a, 1, 0, r, c, v); ft = "R6"; end
      2: begin addf(a, b, 0, r, c, v); ft = "R5"; end
      3: begin addf(a, (~b) & MASK, 1, r, c, v); ft = "R5"; end
      4: begin addf(a, MASK, 0, r, c, v); ft = "R6"; end
      5: begin r = a & b; ft = "R7"; end
      6: begin r = a | b; ft = "R7"; end
      7: begin r = a ^ b; ft = "R7"; end
      8: begin r = (~a) & MASK; ft = "R7"; end
      0: begin r = a; ft = "R7"; end
      default: begin r = a; ft = "R11"; end
    endcase
    wb = md ? mmem[a % 16] : r;
    chk(in_reset_phase ? "R1 a_bus" : "R2/R3 a_bus", a_bus, a);
    chk("R3 b_bus", b_bus, b);
    chk(md ? "R9/R10 wb_data" : (f > 8 ? "R11 wb_data" : "R4/R10 wb_data"), wb_data, wb);
    chk({ft, " flag_v"}, flag_v, v);
    chk({ft, " flag_c"}, flag_c, c);
    fl = (r & TOP) ? 1 : 0;
    chk("R8 flag_n", flag_n, fl);
    chk("R8 flag_z", flag_z, (r == 0) ? 1 : 0);
    @(posedge clk);
    if (w) mregs[d] = wb;
    if (mw) mmem[a % 16] = b;
    @(negedge clk);
  endtask

  task automatic ld(int d, int val);
    step(1, d, 0, 0, 1, val, 2, 0, 0);
  endtask

  initial begin
    #(PER * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mregs[i] = 0;
    for (int i = 0; i < 16; i++) mmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: all registers and memory words read as zero after reset
    for (int i = 0; i < 8; i++) step(0, 0, i, i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      ld(1, i);
      step(0, 0, 1, 0, 0, 0, 0, 0, 1);
    end
    in_reset_phase = 0;
    // R5/R6 corners
    ld(2, 8'h7f); ld(3, 8'h01); ld(4, 8'hff); ld(5, 8'h80);
    step(0, 0, 2, 3, 0, 0, 2, 0, 0);   // 7f+1 overflow
    step(0, 0, 4, 3, 0, 0, 2, 0, 0);   // ff+1 carry, zero
    step(0, 0, 2, 2, 0, 0, 3, 0, 0);   // equal subtract
    step(0, 0, 3, 4, 0, 0, 3, 0, 0);   // borrow
    step(0, 0, 5, 3, 0, 0, 3, 0, 0);   // 80-1 overflow
    step(0, 0, 4, 0, 0, 0, 1, 0, 0);   // inc ff
    step(0, 0, 2, 0, 0, 0, 1, 0, 0);   // inc 7f
    step(0, 0, 0, 0, 0, 0, 4, 0, 0);   // dec 0
    step(0, 0, 5, 0, 0, 0, 4, 0, 0);   // dec 80
    for (int f = 5; f < 16; f++) step(0, 0, 4, 2, 0, 0, f, 0, 0);
    // R9: address wrap and load-after-store, old data on same-edge load
    ld(6, 8'h13);
    step(0, 0, 6, 0, 1, 8'h5a, 0, 1, 1);
    ld(6, 8'h03);
    step(1, 7, 6, 0, 1, 8'ha5, 0, 1, 1);
    step(0, 0, 7, 6, 0, 0, 0, 0, 1);
    step(0, 0, 6, 0, 0, 0, 0, 0, 1);
    // R2: disabled write leaves register
    step(0, 2, 4, 0, 1, 8'h00, 2, 0, 0);
    step(0, 0, 2, 0, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 255),
           $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule